// File: doc/BRIEF.md
# UART Interrupt Request Controller

This block turns the event and level conditions of a UART into one interrupt request and a code that names its source. It watches six sources: the transmit hold register running empty, the transmit shift register finishing a character, the receive buffer or FIFO reaching its fill threshold, a receive idle timeout, an error flag on the byte at the receive read head, and a change on the modem control inputs. Each source has its own set and clear rule. Each rule is tied to a register access that the surrounding UART reports as a one-cycle strobe: a write of the transmit hold register, a read of the receive buffer, a read of line status, or a read of modem status.

Pending conditions are kept whether or not they are enabled. A five-bit enable vector decides which of them reach the request line and the source code. The data-ready and timeout sources share one enable bit. The code and the request are registered together from the next-state pending values, so an access that clears a source takes effect on the outputs in the cycle after the access. The receive storage, the baud timing, the shifters and the register decoding all sit outside the block.

Top module: `uart_irq_ctrl`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `irq_o` is 0 and `id_o` is 3'b000 (nothing pending).
- R2: With enable bit 1 set, a high `thr_empty_i` gives source code 3'b010 in the next cycle. A cycle with `thr_wr_i` high removes that source in the following cycle, even if `thr_empty_i` is still high during the write.
- R3: With enable bit 4 set, a `tsr_done_i` pulse latches a transmit-complete condition (code 3'b011). The condition stays latched until `thr_wr_i`, and a write in the same cycle as `tsr_done_i` wins.
- R4: With enable bit 0 set, data-ready (code 3'b100) is pending in FIFO mode (`fifo_en_i`=1) when the effective count is at least `rx_trig_i`. In single-buffer mode it is pending when the effective count is nonzero. The effective count is `rx_count_i` minus one in a cycle where `rbr_rd_i` is high and the count is nonzero.
- R5: In FIFO mode, an `rx_timeout_i` pulse while 0 < effective count < `rx_trig_i` latches a timeout (code 3'b101, enable bit 0). Reads that leave bytes behind do not clear it. It clears only when the effective count reaches zero. A pulse with an empty FIFO is ignored.
- R6: With enable bit 2 set, line status (code 3'b110) is set when any `head_err_i` bit is high and either no bit was high in the previous cycle or `rbr_rd_i` was high in the previous cycle. It clears when `lsr_rd_i` is high (the read wins) or when all `head_err_i` bits are low.
- R7: With enable bit 3 set, any change of the synchronized `modem_i` bits raises modem status (code 3'b001) three cycles after the input changes. `msr_rd_i` clears it, and a change detected in the same cycle as the read wins.
- R8: When several enabled sources are pending, the code reports the highest one in this order: line status, data-ready, timeout, hold empty, transmit complete, modem status.
- R9: `irq_o` is 1 exactly when `id_o` is not 3'b000. Both change in the cycle after the input, strobe or enable change that causes them.
- R10: Clearing an enable bit hides its source from `irq_o` and `id_o` without discarding the pending state. Setting the bit again shows the source in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ier_i | input | 5 | Enables: bit0 receive data/timeout, bit1 hold empty, bit2 line status, bit3 modem, bit4 transmit complete |
| fifo_en_i | input | 1 | 1 = FIFO mode, 0 = single-buffer mode |
| thr_empty_i | input | 1 | Transmit hold register holds no data |
| tsr_done_i | input | 1 | One-cycle pulse: shift register finished a character |
| thr_wr_i | input | 1 | Strobe: transmit hold register written |
| rx_count_i | input | CNT_W | Bytes held in receive storage |
| rx_trig_i | input | CNT_W | Programmed FIFO trigger level (1 or more) |
| rx_timeout_i | input | 1 | One-cycle pulse: receive idle timeout elapsed |
| rbr_rd_i | input | 1 | Strobe: receive buffer read |
| head_err_i | input | ERR_W | Parity, framing, overrun and break flags of the byte at the read head |
| lsr_rd_i | input | 1 | Strobe: line status read |
| modem_i | input | MOD_W | Asynchronous modem status inputs |
| msr_rd_i | input | 1 | Strobe: modem status read |
| irq_o | output | 1 | Registered interrupt request |
| id_o | output | 3 | Registered source code of the highest pending enabled source |

## Verification
The assertions assume the surrounding UART lowers `rx_count_i` in the cycle after an `rbr_rd_i` strobe. They also assume `thr_empty_i` falls in the cycle after a `thr_wr_i`, and that `head_err_i` changes to the next byte's flags in the cycle after a read. The bench drives its FIFO and hold-register model in exactly that order: each read strobe is followed by a count decrement at the next falling edge, and the hold-empty level drops right after a write. The modem inputs are held still around reset and changed only between falling edges. The set-versus-read race is then placed by counting the two synchronizer stages.

// File: rtl/uart_irq_pkg.sv
// Shared types for the UART interrupt request controller.
// Assumes: the source codes are seen by software, so their values are fixed.
package uart_irq_pkg;

    // Source identification codes; 3'b000 means nothing is pending.
    typedef enum logic [2:0] {
        ID_NONE   = 3'b000,
        ID_MODEM  = 3'b001,
        ID_TXE    = 3'b010,
        ID_TXC    = 3'b011,
        ID_RXDATA = 3'b100,
        ID_RXTO   = 3'b101,
        ID_LINE   = 3'b110
    } irq_id_e;

    // Bit positions inside the enable vector.
    localparam int IE_RX    = 0;
    localparam int IE_TXE   = 1;
    localparam int IE_LINE  = 2;
    localparam int IE_MODEM = 3;
    localparam int IE_TXC   = 4;
    localparam int IE_W     = 5;

    // Next-state pending flags handed from the source trackers to the encoder.
    typedef struct packed {
        logic line;
        logic rxd;
        logic rxto;
        logic txe;
        logic txc;
        logic modem;
    } irq_src_t;

endpackage

// File: rtl/uart_irq_tx_src.sv
// Transmit-side interrupt sources: hold-register empty and shift complete.
// Assumes: thr_empty_i falls in the cycle after a thr_wr_i strobe, and
// tsr_done_i is a single-cycle pulse. Outputs are next-state values.
module uart_irq_tx_src (
    input  logic clk,
    input  logic rst_n,
    input  logic thr_empty_i,
    input  logic tsr_done_i,
    input  logic thr_wr_i,
    output logic txe_nxt_o,
    output logic txc_nxt_o
);

    logic txc_q;
    logic txc_d;

    // Hold-empty is a level; a write in flight masks it.
    always_comb begin
        txe_nxt_o = thr_empty_i && !thr_wr_i;
    end

    // Transmit complete: set by the shift-done pulse, a write has priority.
    always_comb begin
        txc_d = txc_q;
        if (thr_wr_i) begin
            txc_d = 1'b0;
        end else if (tsr_done_i) begin
            txc_d = 1'b1;
        end
        txc_nxt_o = txc_d;
    end

    // Holds the latched transmit-complete condition.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            txc_q <= 1'b0;
        end else begin
            txc_q <= txc_d;
        end
    end

endmodule

// File: rtl/uart_irq_rx_src.sv
// Receive-side interrupt sources: data-ready, idle timeout, line status.
// Assumes: rx_count_i and head_err_i move to the post-read values in the
// cycle after an rbr_rd_i strobe; rx_timeout_i is a single-cycle pulse;
// rx_trig_i is at least 1 in FIFO mode. Outputs are next-state values.
module uart_irq_rx_src #(
    parameter int CNT_W = 5,
    parameter int ERR_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_en_i,
    input  logic [CNT_W-1:0] rx_count_i,
    input  logic [CNT_W-1:0] rx_trig_i,
    input  logic             rx_timeout_i,
    input  logic             rbr_rd_i,
    input  logic [ERR_W-1:0] head_err_i,
    input  logic             lsr_rd_i,
    output logic             rxd_nxt_o,
    output logic             rxto_nxt_o,
    output logic             line_nxt_o
);

    localparam logic [CNT_W-1:0] CNT_ZERO = '0;

    logic [CNT_W-1:0] eff_cnt;
    logic             rd_take;
    logic             to_q;
    logic             to_d;
    logic             line_q;
    logic             line_d;
    logic             err_any;
    logic             err_any_q;
    logic             rd_q;

    // Count as it will be once a read in this cycle has taken its byte.
    always_comb begin
        rd_take = rbr_rd_i && (rx_count_i != CNT_ZERO);
        eff_cnt = rx_count_i - {{(CNT_W-1){1'b0}}, rd_take};
    end

    // Data-ready is a level on the effective count; mode picks the rule.
    always_comb begin
        if (fifo_en_i) begin
            rxd_nxt_o = (eff_cnt >= rx_trig_i);
        end else begin
            rxd_nxt_o = (eff_cnt != CNT_ZERO);
        end
    end

    // Timeout latches below the trigger and drops only when storage is empty.
    always_comb begin
        to_d = to_q;
        if (!fifo_en_i || eff_cnt == CNT_ZERO) begin
            to_d = 1'b0;
        end else if (rx_timeout_i && eff_cnt < rx_trig_i) begin
            to_d = 1'b1;
        end
        rxto_nxt_o = to_d;
    end

    // Line status arms when an error byte newly reaches the head.
    always_comb begin
        err_any = |head_err_i;
        line_d  = line_q;
        if (lsr_rd_i || !err_any) begin
            line_d = 1'b0;
        end else if (!err_any_q || rd_q) begin
            line_d = 1'b1;
        end
        line_nxt_o = line_d;
    end

    // Holds the latched timeout and line-status state and the head history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            to_q      <= 1'b0;
            line_q    <= 1'b0;
            err_any_q <= 1'b0;
            rd_q      <= 1'b0;
        end else begin
            to_q      <= to_d;
            line_q    <= line_d;
            err_any_q <= err_any;
            rd_q      <= rbr_rd_i;
        end
    end

endmodule

// File: rtl/uart_irq_msr_src.sv
// Modem-status interrupt source with input synchronizer and change detect.
// Assumes: modem_i may be asynchronous; comparison is suppressed until the
// synchronizer and reference register hold real samples after reset.
module uart_irq_msr_src #(
    parameter int MOD_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [MOD_W-1:0] modem_i,
    input  logic             msr_rd_i,
    output logic             ms_nxt_o,
    output logic             delta_o
);

    localparam int VLD_W = 3;

    logic [MOD_W-1:0] sync1_q;
    logic [MOD_W-1:0] sync2_q;
    logic [MOD_W-1:0] last_q;
    logic [VLD_W-1:0] vld_q;
    logic             ms_q;
    logic             ms_d;

    // Change against the last sampled value, once the pipeline is primed.
    always_comb begin
        delta_o = vld_q[VLD_W-1] && (sync2_q != last_q);
    end

    // Pending flag: a detected change wins over a status read.
    always_comb begin
        ms_d = ms_q;
        if (delta_o) begin
            ms_d = 1'b1;
        end else if (msr_rd_i) begin
            ms_d = 1'b0;
        end
        ms_nxt_o = ms_d;
    end

    // Two-stage synchronizer, reference register and priming shift.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1_q <= '0;
            sync2_q <= '0;
            last_q  <= '0;
            vld_q   <= '0;
            ms_q    <= 1'b0;
        end else begin
            sync1_q <= modem_i;
            sync2_q <= sync1_q;
            last_q  <= sync2_q;
            vld_q   <= {vld_q[VLD_W-2:0], 1'b1};
            ms_q    <= ms_d;
        end
    end

endmodule

// File: rtl/uart_irq_prio.sv
// Enable gating, fixed-priority source encoding and output registers.
// Assumes: src_i carries next-state pending values, so outputs follow a
// set or clear by exactly one cycle.
module uart_irq_prio
    import uart_irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  irq_src_t        src_i,
    input  logic [IE_W-1:0] ier_i,
    output logic            irq_o,
    output irq_id_e         id_o
);

    irq_src_t gated;
    irq_id_e  id_d;
    logic     any_d;
    irq_id_e  id_q;
    logic     irq_q;

    // Apply per-source enables; receive data and timeout share one bit.
    always_comb begin
        gated.line  = src_i.line  && ier_i[IE_LINE];
        gated.rxd   = src_i.rxd   && ier_i[IE_RX];
        gated.rxto  = src_i.rxto  && ier_i[IE_RX];
        gated.txe   = src_i.txe   && ier_i[IE_TXE];
        gated.txc   = src_i.txc   && ier_i[IE_TXC];
        gated.modem = src_i.modem && ier_i[IE_MODEM];
        any_d       = |gated;
    end

    // Pick the highest-ranked enabled source.
    always_comb begin
        if (gated.line) begin
            id_d = ID_LINE;
        end else if (gated.rxd) begin
            id_d = ID_RXDATA;
        end else if (gated.rxto) begin
            id_d = ID_RXTO;
        end else if (gated.txe) begin
            id_d = ID_TXE;
        end else if (gated.txc) begin
            id_d = ID_TXC;
        end else if (gated.modem) begin
            id_d = ID_MODEM;
        end else begin
            id_d = ID_NONE;
        end
    end

    // Register the request and the code together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
            id_q  <= ID_NONE;
        end else begin
            irq_q <= any_d;
            id_q  <= id_d;
        end
    end

    assign irq_o = irq_q;
    assign id_o  = id_q;

endmodule

// File: rtl/uart_irq_ctrl.sv
// Top of the UART interrupt request controller: connects the transmit,
// receive and modem source trackers to the priority encoder.
// Assumes: all strobes are single-cycle and synchronous to clk.
module uart_irq_ctrl
    import uart_irq_pkg::*;
#(
    parameter int CNT_W = 5,
    parameter int ERR_W = 4,
    parameter int MOD_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [4:0]       ier_i,
    input  logic             fifo_en_i,
    input  logic             thr_empty_i,
    input  logic             tsr_done_i,
    input  logic             thr_wr_i,
    input  logic [CNT_W-1:0] rx_count_i,
    input  logic [CNT_W-1:0] rx_trig_i,
    input  logic             rx_timeout_i,
    input  logic             rbr_rd_i,
    input  logic [ERR_W-1:0] head_err_i,
    input  logic             lsr_rd_i,
    input  logic [MOD_W-1:0] modem_i,
    input  logic             msr_rd_i,
    output logic             irq_o,
    output logic [2:0]       id_o
);

    irq_src_t src;
    irq_id_e  id_enc;
    logic     ms_delta;

    uart_irq_tx_src u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .thr_empty_i(thr_empty_i),
        .tsr_done_i (tsr_done_i),
        .thr_wr_i   (thr_wr_i),
        .txe_nxt_o  (src.txe),
        .txc_nxt_o  (src.txc)
    );

    uart_irq_rx_src #(
        .CNT_W(CNT_W),
        .ERR_W(ERR_W)
    ) u_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .fifo_en_i   (fifo_en_i),
        .rx_count_i  (rx_count_i),
        .rx_trig_i   (rx_trig_i),
        .rx_timeout_i(rx_timeout_i),
        .rbr_rd_i    (rbr_rd_i),
        .head_err_i  (head_err_i),
        .lsr_rd_i    (lsr_rd_i),
        .rxd_nxt_o   (src.rxd),
        .rxto_nxt_o  (src.rxto),
        .line_nxt_o  (src.line)
    );

    uart_irq_msr_src #(
        .MOD_W(MOD_W)
    ) u_ms (
        .clk     (clk),
        .rst_n   (rst_n),
        .modem_i (modem_i),
        .msr_rd_i(msr_rd_i),
        .ms_nxt_o(src.modem),
        .delta_o (ms_delta)
    );

    uart_irq_prio u_prio (
        .clk  (clk),
        .rst_n(rst_n),
        .src_i(src),
        .ier_i(ier_i),
        .irq_o(irq_o),
        .id_o (id_enc)
    );

    assign id_o = id_enc;

endmodule

// File: rtl/uart_irq_chk.sv
// Protocol checker for uart_irq_ctrl, attached with bind below.
// Assumes: the input ordering stated in the brief's verification section.
module uart_irq_chk
    import uart_irq_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic [4:0]       ier_i,
    input logic             fifo_en_i,
    input logic             thr_wr_i,
    input logic [CNT_W-1:0] rx_count_i,
    input logic [CNT_W-1:0] rx_trig_i,
    input logic             rbr_rd_i,
    input logic             lsr_rd_i,
    input logic             msr_rd_i,
    input logic             ms_delta,
    input logic             irq_o,
    input logic [2:0]       id_o
);

    // R9: request and code agree.
    p_irq_matches_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (id_o != ID_NONE));

    // R10: with every enable cleared, the request drops next cycle.
    p_all_masked_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ier_i == 5'b00000) |=> !irq_o);

    // R2 and R3: a hold-register write removes both transmit sources.
    p_thr_write_clears_tx_r3: assert property (@(posedge clk) disable iff (!rst_n)
        thr_wr_i |=> (id_o != ID_TXE && id_o != ID_TXC));

    // R6: a line-status read removes the line source next cycle.
    p_lsr_read_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        lsr_rd_i |=> (id_o != ID_LINE));

    // R4: FIFO at or above trigger reports data-ready unless line outranks it.
    p_fifo_level_reports_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en_i && ier_i[IE_RX] && !rbr_rd_i && rx_trig_i != '0
         && rx_count_i >= rx_trig_i)
        |=> (id_o == ID_RXDATA || id_o == ID_LINE));

    // R7: a modem read with no simultaneous change clears the modem source.
    p_msr_read_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (msr_rd_i && !ms_delta) |=> (id_o != ID_MODEM));

endmodule

bind uart_irq_ctrl uart_irq_chk #(
    .CNT_W(CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ier_i     (ier_i),
    .fifo_en_i (fifo_en_i),
    .thr_wr_i  (thr_wr_i),
    .rx_count_i(rx_count_i),
    .rx_trig_i (rx_trig_i),
    .rbr_rd_i  (rbr_rd_i),
    .lsr_rd_i  (lsr_rd_i),
    .msr_rd_i  (msr_rd_i),
    .ms_delta  (ms_delta),
    .irq_o     (irq_o),
    .id_o      (id_o)
);

// File: tb/tb_uart_irq_ctrl.sv
// Self-checking bench: sweeps the receive level space and walks each
// source's set/clear rules and the priority order.
module tb_uart_irq_ctrl;

    localparam int CNT_W = 5;
    localparam int ERR_W = 4;
    localparam int MOD_W = 4;
    localparam int DEPTH = 16;

    localparam logic [2:0] C_NONE = 3'b000;
    localparam logic [2:0] C_MOD  = 3'b001;
    localparam logic [2:0] C_TXE  = 3'b010;
    localparam logic [2:0] C_TXC  = 3'b011;
    localparam logic [2:0] C_RXD  = 3'b100;
    localparam logic [2:0] C_RXTO = 3'b101;
    localparam logic [2:0] C_LINE = 3'b110;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [4:0]       ier;
    logic             fifo_en;
    logic             thr_empty;
    logic             tsr_done;
    logic             thr_wr;
    logic [CNT_W-1:0] rx_count;
    logic [CNT_W-1:0] rx_trig;
    logic             rx_timeout;
    logic             rbr_rd;
    logic [ERR_W-1:0] head_err;
    logic             lsr_rd;
    logic [MOD_W-1:0] modem;
    logic             msr_rd;
    logic             irq;
    logic [2:0]       id;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    uart_irq_ctrl #(
        .CNT_W(CNT_W),
        .ERR_W(ERR_W),
        .MOD_W(MOD_W)
    ) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .ier_i       (ier),
        .fifo_en_i   (fifo_en),
        .thr_empty_i (thr_empty),
        .tsr_done_i  (tsr_done),
        .thr_wr_i    (thr_wr),
        .rx_count_i  (rx_count),
        .rx_trig_i   (rx_trig),
        .rx_timeout_i(rx_timeout),
        .rbr_rd_i    (rbr_rd),
        .head_err_i  (head_err),
        .lsr_rd_i    (lsr_rd),
        .modem_i     (modem),
        .msr_rd_i    (msr_rd),
        .irq_o       (irq),
        .id_o        (id)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    // One check: code and request (R9 ties the request to the code).
    task automatic expect_id(input string tag, input logic [2:0] exp);
        logic exp_irq;
        exp_irq = (exp != C_NONE);
        tests++;
        if (id !== exp || irq !== exp_irq) begin
            fails++;
            $display("FAIL %s: id=%b irq=%b expected id=%b irq=%b",
                     tag, id, irq, exp, exp_irq);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; ier = '0; fifo_en = 1'b0; thr_empty = 1'b0;
        tsr_done = 1'b0; thr_wr = 1'b0; rx_count = '0; rx_trig = 5'd1;
        rx_timeout = 1'b0; rbr_rd = 1'b0; head_err = '0; lsr_rd = 1'b0;
        modem = '0; msr_rd = 1'b0;
        repeat (3) tick();
        expect_id("R1 in reset", C_NONE);
        rst_n = 1'b1;
        tick();
        expect_id("R1 after reset", C_NONE);

        // R2: hold-register empty level and write clear
        ier = 5'b00010; thr_empty = 1'b1;
        tick(); expect_id("R2 empty raises", C_TXE);
        thr_wr = 1'b1;
        tick(); thr_wr = 1'b0; thr_empty = 1'b0;
        expect_id("R2 write clears", C_NONE);
        tick(); expect_id("R2 stays clear", C_NONE);

        // R3: transmit complete latch, write clear, write wins
        ier = 5'b10000; tsr_done = 1'b1;
        tick(); tsr_done = 1'b0; expect_id("R3 done latches", C_TXC);
        tick(); expect_id("R3 held", C_TXC);
        thr_wr = 1'b1;
        tick(); thr_wr = 1'b0; expect_id("R3 write clears", C_NONE);
        tsr_done = 1'b1; thr_wr = 1'b1;
        tick(); tsr_done = 1'b0; thr_wr = 1'b0;
        expect_id("R3 write beats done", C_NONE);

        // R4: full sweep of count against trigger in FIFO mode
        ier = 5'b00001; fifo_en = 1'b1;
        for (int t = 1; t <= DEPTH; t++) begin
            for (int c = 0; c <= DEPTH; c++) begin
                rx_trig = CNT_W'(t); rx_count = CNT_W'(c);
                tick();
                expect_id("R4 fifo level", (c >= t) ? C_RXD : C_NONE);
            end
        end
        // R4: single-buffer mode ignores the trigger
        fifo_en = 1'b0; rx_trig = 5'd8;
        for (int c = 0; c <= DEPTH; c++) begin
            rx_count = CNT_W'(c);
            tick();
            expect_id("R4 single buffer", (c != 0) ? C_RXD : C_NONE);
        end
        // R4: a read lowers the effective count at once
        fifo_en = 1'b1; rx_trig = 5'd4; rx_count = 5'd4;
        tick(); expect_id("R4 at trigger", C_RXD);
        rbr_rd = 1'b1;
        tick(); rbr_rd = 1'b0; rx_count = 5'd3;
        expect_id("R4 read clears", C_NONE);
        rx_count = 5'd0;
        tick();

        // R5: timeout latch and empty-only clear
        rx_trig = 5'd8; rx_count = 5'd3;
        tick(); expect_id("R5 below trigger", C_NONE);
        rx_timeout = 1'b1;
        tick(); rx_timeout = 1'b0; expect_id("R5 timeout sets", C_RXTO);
        for (int n = 3; n >= 1; n--) begin
            rbr_rd = 1'b1;
            tick(); rbr_rd = 1'b0; rx_count = CNT_W'(n - 1);
            expect_id("R5 read drains", (n > 1) ? C_RXTO : C_NONE);
        end
        rx_timeout = 1'b1;
        tick(); rx_timeout = 1'b0; expect_id("R5 empty ignores pulse", C_NONE);
        rx_count = 5'd2; rx_timeout = 1'b1;
        tick(); rx_timeout = 1'b0; expect_id("R5 set again", C_RXTO);
        rx_count = 5'd9;
        tick(); expect_id("R5 data-ready ranks above", C_RXD);
        rx_count = 5'd2;
        tick(); expect_id("R5 still latched", C_RXTO);
        rx_count = 5'd0;
        tick(); expect_id("R5 empty clears", C_NONE);

        // R6: line status follows the error byte at the head
        ier = 5'b00101; rx_count = 5'd2;
        tick(); expect_id("R6 no error", C_NONE);
        head_err = 4'b0001;
        tick(); expect_id("R6 error at head", C_LINE);
        lsr_rd = 1'b1;
        tick(); lsr_rd = 1'b0; expect_id("R6 status read clears", C_NONE);
        tick(); expect_id("R6 same byte stays clear", C_NONE);
        rbr_rd = 1'b1;
        tick(); rbr_rd = 1'b0; rx_count = 5'd1; head_err = 4'b0010;
        expect_id("R6 before head moves", C_NONE);
        tick(); expect_id("R6 next bad byte", C_LINE);
        head_err = 4'b0000;
        tick(); expect_id("R6 clean head drops", C_NONE);
        rx_count = 5'd0;
        tick();

        // R7: modem change, read clear, change beats read
        ier = 5'b01000; modem = 4'b0100;
        repeat (3) tick();
        expect_id("R7 change raises", C_MOD);
        msr_rd = 1'b1;
        tick(); msr_rd = 1'b0; expect_id("R7 read clears", C_NONE);
        modem = 4'b0110;
        tick(); tick();
        msr_rd = 1'b1;
        tick(); msr_rd = 1'b0; expect_id("R7 change beats read", C_MOD);
        msr_rd = 1'b1;
        tick(); msr_rd = 1'b0; expect_id("R7 second read clears", C_NONE);

        // R10: masked source keeps its pending state
        ier = 5'b00000; modem = 4'b0000;
        repeat (4) tick();
        expect_id("R10 masked hides", C_NONE);
        ier = 5'b01000;
        tick(); expect_id("R10 unmask shows", C_MOD);

        // R8: priority walk with every source pending
        ier = 5'b11111; tsr_done = 1'b1; thr_empty = 1'b1;
        rx_trig = 5'd4; rx_count = 5'd5; head_err = 4'b1000;
        tick(); tsr_done = 1'b0; expect_id("R8 line on top", C_LINE);
        lsr_rd = 1'b1;
        tick(); lsr_rd = 1'b0; expect_id("R8 data-ready next", C_RXD);
        rx_count = 5'd0; head_err = 4'b0000;
        tick(); expect_id("R8 hold empty next", C_TXE);
        thr_empty = 1'b0;
        tick(); expect_id("R8 transmit complete next", C_TXC);
        thr_wr = 1'b1;
        tick(); thr_wr = 1'b0; expect_id("R8 modem last", C_MOD);
        msr_rd = 1'b1;
        tick(); msr_rd = 1'b0; expect_id("R8 all clear", C_NONE);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule